// File: doc/BRIEF.md
# Indexed Block-Transfer Configuration Register Slave

This block is a serial two-wire bus slave that holds seven byte-wide configuration registers for a clock fan-out buffer. A host reaches it with indexed block transfers. To write, the host sends the write address, a starting index and a byte count, then the data bytes. To read, the host sends the write address and the index, then a repeated start and the read address. The slave then returns the value of its byte-count register, followed by register bytes starting at the index, for as long as the host acknowledges.

The clock and data lines are oversampled in the system clock domain. Start, repeated start and stop are decoded from line edges. The data line is an open-drain output: the slave only pulls it low. The register fields come out as plain level signals that steer the downstream output and stop logic: power-down and stop drive modes, PLL bandwidth, bypass and divider selects, four output enables and four stoppable selects.

Top module: `smbr_ctl_slave`

## Requirements
- R1: After reset, the register bytes read 0x07, 0x66, 0x00, 0x00, {REV_ID,VENDOR_ID} (0x01 by default), 0x08 and 0x05 at indices 0 to 6, and `sda_oe` is low.
- R2: The slave acknowledges the write address 0xDC and the read address 0xDD. It does not acknowledge any other address byte, and it then ignores the bus until the next start.
- R3: In a write, the byte after the address is the index and the next byte is the count. Each data byte is acknowledged and stored at the index, and the index advances by one per byte.
- R4: Data bytes beyond the count are not acknowledged and are not stored.
- R5: In a read, the first byte the slave returns is the byte-count register (index 6). Register bytes from the index follow. The slave stops sending and releases the line after the host not-acknowledges a byte.
- R6: Index 4 is read-only. Bits 5:3 of index 0 and bits 7, 4, 3 and 0 of indices 1 and 2 are reserved: they read as 0 and ignore writes. Such writes are still acknowledged.
- R7: Indices 7 and above read as 0x00. Writes to them are acknowledged but change nothing.
- R8: A stop or a start in the middle of a byte aborts the transfer. Bytes already completed stay written, and the next start begins a new transfer.
- R9: The slave changes `sda_oe` only while the clock line is low. Each acknowledge it gives holds the line low through the ninth clock.
- R10: The field outputs map from index 0 as follows: bit 7 to `pd_tristate`, bit 6 to `stop_tristate`, bit 2 to `bw_low`, bit 1 to `pll_mode`, bit 0 to `div_one`. Bits 6, 5, 2 and 1 of index 1 drive `out_en[3:0]`, and the same bits of index 2 drive `out_stoppable[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| pd_tristate | output | 1 | Power-down drive mode, 1 = outputs floated |
| stop_tristate | output | 1 | Stop drive mode, 1 = outputs floated |
| bw_low | output | 1 | PLL bandwidth select, 1 = low |
| pll_mode | output | 1 | 1 = PLL, 0 = fan-out bypass |
| div_one | output | 1 | 1 = divide by one, 0 = divide by two |
| out_en | output | 4 | Per-output enable |
| out_stoppable | output | 4 | Per-output stoppable select, 0 = free-running |

## Verification
The in-line assertions watch, on every cycle, the bus-level rules that do not depend on register contents. They check that the slave drives the line only while the clock is low, that it stays silent when idle, that a start or stop immediately resets the byte engine, that each stored byte consumes one unit of the write count, and that writes to the read-only and out-of-range indices leave the register bank unchanged. The directed scenarios show what only whole transactions reveal: the reset contents, the write masks, the field-to-port mapping, the count-first read order, the refusal of surplus bytes, and the survival of completed bytes across an aborted transfer.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

  localparam int REG_COUNT = 7;
  localparam int IDX_W     = 8;
  localparam int RO_IDX    = 4;
  localparam int CNT_IDX   = 6;
  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TACK
  } bus_st_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_IDX,
    RL_CNT,
    RL_DATA
  } rx_role_e;

  function automatic logic [7:0] wr_mask(input int idx);
    case (idx)
      0:       return 8'hC7;
      1, 2:    return 8'h66;
      3, 5, 6: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(input int idx);
    case (idx)
      0:       return 8'h07;
      1:       return 8'h66;
      5:       return 8'h08;
      6:       return 8'h05;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbr_line_sync.sv
module smbr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sr_q, scl_sr_d;
  logic [STAGES-1:0] sda_sr_q, sda_sr_d;
  logic              scl_prev_q, sda_prev_q;

  generate
    if (STAGES == 1) begin : g_one
      assign scl_sr_d = scl_i;
      assign sda_sr_d = sda_i;
    end else begin : g_many
      assign scl_sr_d = {scl_sr_q[STAGES-2:0], scl_i};
      assign sda_sr_d = {sda_sr_q[STAGES-2:0], sda_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr_q   <= '1;
      sda_sr_q   <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sr_q   <= scl_sr_d;
      sda_sr_q   <= sda_sr_d;
      scl_prev_q <= scl_sr_q[STAGES-1];
      sda_prev_q <= sda_sr_q[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sr_q[STAGES-1];
  assign sda_lvl   = sda_sr_q[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev_q;
  assign scl_fall  = ~scl_lvl & scl_prev_q;
  assign start_det = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;

endmodule

// File: rtl/smbr_regfile.sv
module smbr_regfile
  import smbr_pkg::*;
#(
  parameter logic [3:0] REV_ID  = 4'h0,
  parameter logic [3:0] VEND_ID = 4'h1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [7:0]             wr_data,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [7:0]             rd_data,
  output logic [7:0]             count_byte,
  output logic [REG_COUNT*8-1:0] bank
);

  generate
    for (genvar g = 0; g < REG_COUNT; g++) begin : g_byte
      localparam logic [7:0] MASK = wr_mask(g);
      localparam logic [7:0] RSTV = rst_val(g) & MASK;
      if (g == RO_IDX) begin : g_ro
        assign bank[g*8 +: 8] = {REV_ID, VEND_ID};
      end else begin : g_rw
        logic [7:0] q, d;
        logic       en;
        assign en = wr_en && (wr_idx == IDX_W'(g));
        assign d  = (q & ~MASK) | (wr_data & MASK);
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)  q <= RSTV;
          else if (en) q <= d;
        end
        assign bank[g*8 +: 8] = q;
      end
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = bank[i*8 +: 8];
    end
  end

  assign count_byte = bank[CNT_IDX*8 +: 8];

  AST_OOR_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= IDX_W'(REG_COUNT)) |=> $stable(bank)) else $error("oor"); // R7

  AST_RO_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_W'(RO_IDX)) |=> $stable(bank)) else $error("ro"); // R6

endmodule

// File: rtl/smbr_engine.sv
module smbr_engine
  import smbr_pkg::*;
#(
  parameter logic [7:0] WR_ADDR = 8'hDC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  input  logic [7:0]       count_byte,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             sda_oe
);

  localparam logic [7:0] RD_ADDR = WR_ADDR | 8'h01;
  localparam int BCNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_BITS - 1);
  localparam logic [BCNT_W-1:0] FULL     = BCNT_W'(BYTE_BITS);

  bus_st_e           st_q, st_d;
  rx_role_e          role_q, role_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [7:0]        sh_q, sh_d, tx_q, tx_d, left_q, left_d;
  logic [IDX_W-1:0]  ptr_q, ptr_d;
  logic              rdm_q, rdm_d, first_q, first_d, ackp_q, ackp_d;
  logic              hack_q, hack_d, tseen_q, tseen_d, oe_q, oe_d;
  logic [7:0]        byte_in, load_val;

  assign byte_in  = {sh_q[6:0], sda_lvl};
  assign load_val = first_q ? count_byte : rd_data;

  always_comb begin
    st_d = st_q;   role_d = role_q;  bcnt_d = bcnt_q;  sh_d = sh_q;
    tx_d = tx_q;   left_d = left_q;  ptr_d = ptr_q;    rdm_d = rdm_q;
    first_d = first_q; ackp_d = ackp_q; hack_d = hack_q; tseen_d = tseen_q;
    oe_d = oe_q;   wr_en = 1'b0;
    if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start_det) begin
      st_d   = ST_RX;
      role_d = RL_ADDR;
      bcnt_d = '0;
      rdm_d  = 1'b0;
      ackp_d = 1'b0;
      oe_d   = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise && bcnt_q < FULL) begin
            sh_d   = byte_in;
            bcnt_d = bcnt_q + 1'b1;
            if (bcnt_q == LAST_BIT) begin
              ackp_d = 1'b1;
              case (role_q)
                RL_ADDR: begin
                  if (byte_in == WR_ADDR) begin
                    role_d = RL_IDX;
                  end else if (byte_in == RD_ADDR) begin
                    rdm_d   = 1'b1;
                    first_d = 1'b1;
                  end else begin
                    ackp_d = 1'b0;
                  end
                end
                RL_IDX: begin
                  ptr_d  = byte_in;
                  role_d = RL_CNT;
                end
                RL_CNT: begin
                  left_d = byte_in;
                  role_d = RL_DATA;
                end
                default: begin
                  if (left_q != 8'd0) begin
                    wr_en  = 1'b1;
                    ptr_d  = ptr_q + 1'b1;
                    left_d = left_q - 8'd1;
                  end else begin
                    ackp_d = 1'b0;
                  end
                end
              endcase
            end
          end
          if (scl_fall && bcnt_q == FULL) begin
            if (ackp_q) begin
              st_d = ST_ACK;
              oe_d = 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bcnt_d = '0;
            if (rdm_q) begin
              tx_d    = load_val;
              oe_d    = ~load_val[7];
              first_d = 1'b0;
              if (!first_q) ptr_d = ptr_q + 1'b1;
              st_d    = ST_TX;
            end else begin
              oe_d = 1'b0;
              st_d = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) bcnt_d = bcnt_q + 1'b1;
          if (scl_fall) begin
            if (bcnt_q == FULL) begin
              oe_d    = 1'b0;
              tseen_d = 1'b0;
              st_d    = ST_TACK;
            end else begin
              tx_d = {tx_q[6:0], 1'b0};
              oe_d = ~tx_q[6];
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            hack_d  = ~sda_lvl;
            tseen_d = 1'b1;
          end
          if (scl_fall && tseen_q) begin
            if (hack_q) begin
              tx_d   = rd_data;
              oe_d   = ~rd_data[7];
              ptr_d  = ptr_q + 1'b1;
              bcnt_d = '0;
              st_d   = ST_TX;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  role_q <= RL_ADDR; bcnt_q <= '0;   sh_q <= '0;
      tx_q <= '0;       left_q <= '0;      ptr_q <= '0;    rdm_q <= 1'b0;
      first_q <= 1'b0;  ackp_q <= 1'b0;    hack_q <= 1'b0; tseen_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      st_q <= st_d;     role_q <= role_d;  bcnt_q <= bcnt_d; sh_q <= sh_d;
      tx_q <= tx_d;     left_q <= left_d;  ptr_q <= ptr_d;   rdm_q <= rdm_d;
      first_q <= first_d; ackp_q <= ackp_d; hack_q <= hack_d; tseen_q <= tseen_d;
      oe_q <= oe_d;
    end
  end

  assign wr_idx  = ptr_q;
  assign rd_idx  = ptr_q;
  assign wr_data = byte_in;
  assign sda_oe  = oe_q;

  AST_DRIVE_WHEN_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(!scl_lvl)) else $error("drive"); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !oe_q) else $error("idle"); // R2

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (st_q == ST_RX && bcnt_q == '0 && !oe_q)) else $error("start"); // R8

  AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st_q == ST_IDLE && !oe_q)) else $error("stop"); // R8

  AST_WRITE_USES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (left_q == $past(left_q) - 8'd1)) else $error("count"); // R4

endmodule

// File: rtl/smbr_ctl_slave.sv
module smbr_ctl_slave
  import smbr_pkg::*;
#(
  parameter logic [7:0] WR_ADDR     = 8'hDC,
  parameter logic [3:0] REV_ID      = 4'h0,
  parameter logic [3:0] VENDOR_ID   = 4'h1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       pd_tristate,
  output logic       stop_tristate,
  output logic       bw_low,
  output logic       pll_mode,
  output logic       div_one,
  output logic [3:0] out_en,
  output logic [3:0] out_stoppable
);

  logic [1:0] rst_sr_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr_q <= 2'b00;
    else        rst_sr_q <= {rst_sr_q[0], 1'b1};
  end
  assign rst_int_n = rst_sr_q[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data, count_byte;
  logic [REG_COUNT*8-1:0] bank;

  smbr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbr_engine #(.WR_ADDR(WR_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_int_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .count_byte(count_byte), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .sda_oe(sda_oe)
  );

  smbr_regfile #(.REV_ID(REV_ID), .VEND_ID(VENDOR_ID)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .count_byte(count_byte), .bank(bank)
  );

  assign pd_tristate   = bank[7];
  assign stop_tristate = bank[6];
  assign bw_low        = bank[2];
  assign pll_mode      = bank[1];
  assign div_one       = bank[0];
  assign out_en        = {bank[8+6], bank[8+5], bank[8+2], bank[8+1]};
  assign out_stoppable = {bank[16+6], bank[16+5], bank[16+2], bank[16+1]};

endmodule

// File: tb/smbr_ctl_slave_bench.sv
module smbr_ctl_slave_bench;

  localparam int Q = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl_h, sda_h;
  logic sda_oe, pd_tristate, stop_tristate, bw_low, pll_mode, div_one;
  logic [3:0] out_en, out_stoppable;
  logic sda_bus;
  assign sda_bus = sda_h & ~sda_oe;

  smbr_ctl_slave u_smbr_ctl_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus), .sda_oe(sda_oe),
    .pd_tristate(pd_tristate), .stop_tristate(stop_tristate), .bw_low(bw_low),
    .pll_mode(pll_mode), .div_one(div_one), .out_en(out_en), .out_stoppable(out_stoppable)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int viol    = 0;
  logic oe_prev = 1'b0;
  logic [7:0] wbuf [8];
  logic       ackv [8];
  logic [7:0] rbuf [9];

  always @(negedge clk) begin
    if (rst_n === 1'b1 && sda_oe !== oe_prev && scl_h === 1'b1) viol++;
    oe_prev = sda_oe;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wt(Q); scl_h = 1'b1; wt(Q); sda_h = 1'b0; wt(Q); scl_h = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wt(Q); scl_h = 1'b1; wt(Q); sda_h = 1'b1; wt(Q);
  endtask

  task automatic bit_out(input logic b);
    sda_h = b; wt(Q); scl_h = 1'b1; wt(2*Q); scl_h = 1'b0; wt(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_h = 1'b1; wt(Q); scl_h = 1'b1; wt(Q); b = sda_bus; wt(Q); scl_h = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(nack);
  endtask

  task automatic wr_block(input logic [7:0] idx, input logic [7:0] cnt, input int n);
    logic a;
    bus_start();
    send_byte(8'hDC, a); chk("R2 write address ack", {7'd0, a}, 8'd1);
    send_byte(idx, a);   chk("R3 index ack", {7'd0, a}, 8'd1);
    send_byte(cnt, a);   chk("R3 count ack", {7'd0, a}, 8'd1);
    for (int i = 0; i < n; i++) send_byte(wbuf[i], ackv[i]);
    bus_stop();
  endtask

  task automatic rd_block(input logic [7:0] idx, input int n);
    logic a;
    bus_start();
    send_byte(8'hDC, a);
    send_byte(idx, a);
    bus_start();
    send_byte(8'hDD, a); chk("R2 read address ack", {7'd0, a}, 8'd1);
    recv_byte(rbuf[0], n == 0);
    for (int i = 1; i <= n; i++) recv_byte(rbuf[i], i == n);
    wt(Q);
    chk("R5 line released after nack", {7'd0, sda_oe}, 8'd0);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 sda_oe", {7'd0, sda_oe}, 8'd0);
    chk("R1 field outputs", {3'd0, pd_tristate, stop_tristate, bw_low, pll_mode, div_one}, 8'h07);
    chk("R1 out_en", {4'd0, out_en}, 8'h0F);
    chk("R1 out_stoppable", {4'd0, out_stoppable}, 8'h00);
    rd_block(8'd0, 7);
    chk("R5 count byte first", rbuf[0], 8'h05);
    chk("R1 idx0", rbuf[1], 8'h07);
    chk("R1 idx1", rbuf[2], 8'h66);
    chk("R1 idx2", rbuf[3], 8'h00);
    chk("R1 idx3", rbuf[4], 8'h00);
    chk("R1 idx4 ids", rbuf[5], 8'h01);
    chk("R1 idx5", rbuf[6], 8'h08);
    chk("R1 idx6", rbuf[7], 8'h05);
  endtask

  task automatic t_fields();
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
    wr_block(8'd0, 8'd3, 3);
    for (int i = 0; i < 3; i++) chk("R3 data ack", {7'd0, ackv[i]}, 8'd1);
    rd_block(8'd0, 3);
    chk("R6 idx0 masked", rbuf[1], 8'hC7);
    chk("R6 idx1 masked", rbuf[2], 8'h66);
    chk("R6 idx2 masked", rbuf[3], 8'h66);
    chk("R10 modes all set", {3'd0, pd_tristate, stop_tristate, bw_low, pll_mode, div_one}, 8'h1F);
    chk("R10 stoppable all", {4'd0, out_stoppable}, 8'h0F);
    wbuf[0] = 8'h02; wbuf[1] = 8'h24; wbuf[2] = 8'h40;
    wr_block(8'd0, 8'd3, 3);
    chk("R10 modes mixed", {3'd0, pd_tristate, stop_tristate, bw_low, pll_mode, div_one}, 8'h02);
    chk("R10 out_en map", {4'd0, out_en}, 8'h06);
    chk("R10 stoppable map", {4'd0, out_stoppable}, 8'h08);
  endtask

  task automatic t_count_limit();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_block(8'd5, 8'd1, 2);
    chk("R4 counted byte ack", {7'd0, ackv[0]}, 8'd1);
    chk("R4 surplus byte nack", {7'd0, ackv[1]}, 8'd0);
    rd_block(8'd5, 2);
    chk("R4 count reg untouched", rbuf[0], 8'h05);
    chk("R3 idx5 written", rbuf[1], 8'h11);
    chk("R4 idx6 untouched", rbuf[2], 8'h05);
  endtask

  task automatic t_readonly();
    wbuf[0] = 8'hFF;
    wr_block(8'd4, 8'd1, 1);
    chk("R6 ro write acked", {7'd0, ackv[0]}, 8'd1);
    rd_block(8'd4, 1);
    chk("R6 ro byte kept", rbuf[1], 8'h01);
  endtask

  task automatic t_out_of_range();
    wbuf[0] = 8'h55; wbuf[1] = 8'hAA;
    wr_block(8'd7, 8'd2, 2);
    chk("R7 oor ack 0", {7'd0, ackv[0]}, 8'd1);
    chk("R7 oor ack 1", {7'd0, ackv[1]}, 8'd1);
    rd_block(8'd7, 2);
    chk("R7 count intact", rbuf[0], 8'h05);
    chk("R7 oor read 7", rbuf[1], 8'h00);
    chk("R7 oor read 8", rbuf[2], 8'h00);
  endtask

  task automatic t_foreign();
    logic a;
    bus_start();
    send_byte(8'hA0, a); chk("R2 foreign nack", {7'd0, a}, 8'd0);
    send_byte(8'h05, a); chk("R2 ignored after nack", {7'd0, a}, 8'd0);
    send_byte(8'h99, a); chk("R2 still ignored", {7'd0, a}, 8'd0);
    bus_stop();
    bus_start();
    send_byte(8'hDE, a); chk("R2 near address nack", {7'd0, a}, 8'd0);
    bus_stop();
    rd_block(8'd5, 1);
    chk("R2 regs unchanged", rbuf[1], 8'h11);
  endtask

  task automatic t_abort();
    logic a;
    bus_start();
    send_byte(8'hDC, a); send_byte(8'd3, a); send_byte(8'd2, a);
    send_byte(8'h5A, a); chk("R8 first byte ack", {7'd0, a}, 8'd1);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_stop();
    rd_block(8'd3, 2);
    chk("R8 completed byte kept", rbuf[1], 8'h5A);
    chk("R8 next idx intact", rbuf[2], 8'h01);
    bus_start();
    send_byte(8'hDC, a); send_byte(8'd3, a); send_byte(8'd1, a);
    for (int i = 0; i < 3; i++) bit_out(1'b0);
    bus_start();
    send_byte(8'hDC, a); chk("R8 restart ack", {7'd0, a}, 8'd1);
    send_byte(8'd3, a); send_byte(8'd1, a);
    send_byte(8'h77, a); chk("R8 restart data ack", {7'd0, a}, 8'd1);
    bus_stop();
    rd_block(8'd3, 1);
    chk("R8 write after restart", rbuf[1], 8'h77);
  endtask

  task automatic t_count_reg();
    wbuf[0] = 8'h02;
    wr_block(8'd6, 8'd1, 1);
    rd_block(8'd1, 2);
    chk("R5 programmed count first", rbuf[0], 8'h02);
    chk("R5 data idx1", rbuf[1], 8'h24);
    chk("R5 data idx2", rbuf[2], 8'h40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl_h = 1'b1; sda_h = 1'b1;
    wt(5);
    rst_n = 1'b1;
    wt(6);
    t_reset();
    t_fields();
    t_count_limit();
    t_readonly();
    t_out_of_range();
    t_foreign();
    t_abort();
    t_count_reg();
    chk("R9 drive changes with scl high", viol[7:0], 8'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule